// File: doc/BRIEF.md
# Test-Mode Entry and Deterministic Reset Sequencer

This block decides when a clock-distribution device is in its factory test mode and, while it is, runs a reset sequence that makes the device's state deterministic. A decoded three-level mode code selects test mode at its middle level. In test mode the reference input replaces the PLL output as the clock source, and the feedback path is forced low. The block drives two control outputs for these, `bypass_sel` and `fb_force_low`.

While test mode is active, raising the disable request tri-states every clock output at once. The block then counts rising edges of the reference input, which it synchronizes and edge-detects on the system clock. When the fifth edge arrives, it holds the downstream divider and skew state machines in their known state. The outputs stay off and the state machines stay held until the request drops or test mode is left. Either of those clears the edge count, so the next request needs a fresh run of edges. The block only issues the controls; the three-level receiver and the state machines are outside it.

Top module: `tmrst_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `bypass_sel`=0, `fb_force_low`=0, `out_oe`=1 and `fsm_hold`=0.
- R2: Mode code 2'b01 (middle level) sampled at a clock edge drives `bypass_sel` and `fb_force_low` high from that edge onward. Codes 2'b00 (low), 2'b10 (high) and 2'b11 drive both low.
- R3: A mode code that is at 2'b01 for a single clock cycle produces exactly one cycle of `bypass_sel` and `fb_force_low`.
- R4: Outside test mode, `dis_req` has no effect: `out_oe` stays 1 and `fsm_hold` stays 0.
- R5: With mode 2'b01 and `dis_req`=1 sampled at an edge, `out_oe` is 0 after that edge.
- R6: `fsm_hold` rises only once EDGE_COUNT (default 5) rising edges of `ref_in` have been seen during a request. With one edge fewer it stays 0.
- R7: Once `fsm_hold` is set, it and `out_oe`=0 persist while the request stays active, whatever further reference edges arrive.
- R8: Releasing `dis_req` returns `out_oe` to 1 and `fsm_hold` to 0 one edge later, and clears the count: a new request needs EDGE_COUNT fresh edges.
- R9: Leaving test mode while `dis_req` is held also releases the outputs and clears the count.
- R10: A reference that is already high when the request starts is not counted as an edge; only low-to-high transitions during the request count.
- R11: `fsm_hold` is never 1 while `out_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 2 | Decoded mode level: 00 low, 01 middle (test), 10 high |
| dis_req | input | 1 | Output disable / deterministic reset request |
| ref_in | input | 1 | Reference clock input, asynchronous to `clk` |
| bypass_sel | output | 1 | Selects the reference in place of the PLL output |
| fb_force_low | output | 1 | Forces the feedback input low |
| out_oe | output | 1 | Clock output enable (0 = high impedance) |
| fsm_hold | output | 1 | Holds the divider and skew state machines in their known state |

## Verification
The bench instantiates the block with EDGE_COUNT=5 and SYNC_STAGES=2. It drives slow reference pulses of four clocks high and four clocks low, so the two-stage synchronizer and the one-cycle counting delay settle before each sample. With a count of five, the bench can test both the four-edge and five-edge boundaries, along with saturation under extra edges. It also covers clearing the count by releasing the request, clearing it by leaving test mode, and a reference that is already high when the request starts.

// File: rtl/tmrst_pkg.sv
// Package: shared encodings for the test-mode reset sequencer.
// Assumes the mode code arrives already decoded from the three-level pin.
package tmrst_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } mode_lvl_e;

endpackage

// File: rtl/tmrst_mode_qual.sv
// Module: registers the mode level and the disable request and
// reports whether test mode is active and a hold is being requested.
// Assumes mode_code is a static decode; any single-cycle MID still counts.
module tmrst_mode_qual
    import tmrst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_code,
    input  logic       dis_req,
    output logic       test_mode,
    output logic       hold_req
);

    logic is_mid;
    logic dis_q;

    // Decode the middle level.
    always_comb begin
        is_mid = (mode_lvl_e'(mode_code) == LVL_MID);
    end

    // Capture test-mode state and request once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_mode <= 1'b0;
            dis_q     <= 1'b0;
        end else begin
            test_mode <= is_mid;
            dis_q     <= dis_req;
        end
    end

    // A hold request exists only inside test mode.
    always_comb begin
        hold_req = test_mode & dis_q;
    end

endmodule

// File: rtl/tmrst_edge_sync.sv
// Module: brings the reference input into the clk domain and emits a
// one-cycle pulse on each low-to-high transition.
// Assumes the reference is slower than clk/2 (SYNC_STAGES >= 2).
module tmrst_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the raw reference through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ref_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising transition of the synchronized level.
    always_comb begin
        rise = sync_q[SYNC_STAGES-1] & ~last_q;
    end

endmodule

// File: rtl/tmrst_edge_cnt.sv
// Module: counts reference edges up to EDGE_COUNT and saturates.
// Assumes clear has priority; done is valid from the counter register.
module tmrst_edge_cnt #(
    parameter int EDGE_COUNT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic done
);

    localparam int              CNT_W  = $clog2(EDGE_COUNT + 1);
    localparam logic [CNT_W-1:0] TARGET = CNT_W'(EDGE_COUNT);

    logic [CNT_W-1:0] cnt_q;

    // Saturating edge counter with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TARGET)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the saturated count.
    always_comb begin
        done = (cnt_q == TARGET);
    end

endmodule

// File: rtl/tmrst_seq.sv
// Module: top of the test-mode deterministic reset sequencer.
// Drives bypass, feedback forcing, output enable and state-machine hold.
// Assumes ref_in is asynchronous and slower than clk/2.
module tmrst_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_COUNT  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_code,
    input  logic       dis_req,
    input  logic       ref_in,
    output logic       bypass_sel,
    output logic       fb_force_low,
    output logic       out_oe,
    output logic       fsm_hold
);

    logic test_mode;
    logic hold_req;
    logic ref_rise;
    logic cnt_done;

    tmrst_mode_qual u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_code (mode_code),
        .dis_req   (dis_req),
        .test_mode (test_mode),
        .hold_req  (hold_req)
    );

    tmrst_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .rise   (ref_rise)
    );

    tmrst_edge_cnt #(.EDGE_COUNT(EDGE_COUNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~hold_req),
        .inc   (ref_rise),
        .done  (cnt_done)
    );

    // Drive the control outputs from the registered state.
    always_comb begin
        bypass_sel   = test_mode;
        fb_force_low = test_mode;
        out_oe       = ~hold_req;
        fsm_hold     = hold_req & cnt_done;
    end

endmodule

// File: rtl/tmrst_seq_chk.sv
// Module: property checker for tmrst_seq, attached by bind.
module tmrst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_code,
    input logic       dis_req,
    input logic       bypass_sel,
    input logic       fb_force_low,
    input logic       out_oe,
    input logic       fsm_hold
);

    logic past_ok;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_bypass_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (bypass_sel == ($past(mode_code) == 2'b01)));

    a_r2_fb_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (fb_force_low == ($past(mode_code) == 2'b01)));

    a_r4_ignore_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode_code) != 2'b01) |-> (out_oe && !fsm_hold));

    a_r5_disable_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode_code) == 2'b01 && $past(dis_req)) |-> !out_oe);

    a_r7_hold_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(fsm_hold) && $past(dis_req) && $past(mode_code) == 2'b01)
        |-> fsm_hold);

    a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(dis_req)) |-> (out_oe && !fsm_hold));

    a_r11_hold_implies_off: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_hold |-> !out_oe);

endmodule

bind tmrst_seq tmrst_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_code    (mode_code),
    .dis_req      (dis_req),
    .bypass_sel   (bypass_sel),
    .fb_force_low (fb_force_low),
    .out_oe       (out_oe),
    .fsm_hold     (fsm_hold)
);

// File: tb/tb_tmrst_seq.sv
module tb_tmrst_seq;

    localparam int CLK_PERIOD = 10;
    localparam int N_EDGES    = 5;
    localparam int N_VEC      = 7;

    // {mode, dis_req, exp_bypass, exp_oe}
    localparam logic [4:0] VEC [N_VEC] = '{
        5'b00_0_0_1, 5'b01_0_1_1, 5'b10_0_0_1, 5'b11_0_0_1,
        5'b00_1_0_1, 5'b10_1_0_1, 5'b01_1_1_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_code = 2'b01;
    logic       dis_req = 1'b1;
    logic       ref_in = 1'b0;
    logic       bypass_sel, fb_force_low, out_oe, fsm_hold;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmrst_seq #(.SYNC_STAGES(2), .EDGE_COUNT(N_EDGES)) dut (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .dis_req(dis_req),
        .ref_in(ref_in), .bypass_sel(bypass_sel), .fb_force_low(fb_force_low),
        .out_oe(out_oe), .fsm_hold(fsm_hold)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic ref_pulses(int n);
        for (int i = 0; i < n; i++) begin
            ref_in = 1'b1; repeat (4) step();
            ref_in = 1'b0; repeat (4) step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with test mode and request driven
        repeat (3) step();
        check("R1 bypass", bypass_sel, 1'b0);
        check("R1 fb", fb_force_low, 1'b0);
        check("R1 oe", out_oe, 1'b1);
        check("R1 hold", fsm_hold, 1'b0);
        mode_code = 2'b00; dis_req = 1'b0;
        rst_n = 1'b1;
        step();
        check("R1 oe after release", out_oe, 1'b1);

        // R2 R4 R5: table of mode/request vectors
        for (int v = 0; v < N_VEC; v++) begin
            mode_code = VEC[v][4:3];
            dis_req   = VEC[v][2];
            step();
            check("R2 bypass", bypass_sel, VEC[v][1]);
            check("R2 fb", fb_force_low, VEC[v][1]);
            check("R4/R5 oe", out_oe, VEC[v][0]);
            check("R4 hold", fsm_hold, 1'b0);
        end
        mode_code = 2'b00; dis_req = 1'b0; step();

        // R4: edges outside test mode with request held
        dis_req = 1'b1; ref_pulses(N_EDGES + 1);
        check("R4 oe idle", out_oe, 1'b1);
        check("R4 hold idle", fsm_hold, 1'b0);
        dis_req = 1'b0;

        // R3: single-cycle pass through middle level
        mode_code = 2'b00; step();
        mode_code = 2'b01; step();
        check("R3 pulse bypass", bypass_sel, 1'b1);
        check("R3 pulse fb", fb_force_low, 1'b1);
        mode_code = 2'b10; step();
        check("R3 pulse end", bypass_sel, 1'b0);
        mode_code = 2'b00; step();

        // R10 R6: reference high at request time, then count edges
        mode_code = 2'b01; ref_in = 1'b1; repeat (4) step();
        dis_req = 1'b1; repeat (3) step();
        check("R5 oe off", out_oe, 1'b0);
        ref_in = 1'b0; repeat (4) step();
        ref_pulses(N_EDGES - 1);
        check("R10 R6 no hold at four", fsm_hold, 1'b0);
        ref_pulses(1);
        check("R6 hold at five", fsm_hold, 1'b1);
        check("R6 oe off", out_oe, 1'b0);

        // R7: extra edges keep the hold
        ref_pulses(2);
        check("R7 hold stays", fsm_hold, 1'b1);
        check("R7 oe stays off", out_oe, 1'b0);

        // R8: release and re-request
        dis_req = 1'b0; step();
        check("R8 oe back", out_oe, 1'b1);
        check("R8 hold off", fsm_hold, 1'b0);
        check("R8 bypass kept", bypass_sel, 1'b1);
        dis_req = 1'b1; step();
        ref_pulses(N_EDGES - 1);
        check("R8 count cleared", fsm_hold, 1'b0);
        ref_pulses(1);
        check("R8 hold again", fsm_hold, 1'b1);
        check("R11 hold implies off", out_oe, 1'b0);

        // R9: leave test mode with request held, then return
        mode_code = 2'b10; step();
        check("R9 oe back", out_oe, 1'b1);
        check("R9 hold off", fsm_hold, 1'b0);
        check("R9 bypass off", bypass_sel, 1'b0);
        mode_code = 2'b01; step();
        check("R9 oe off again", out_oe, 1'b0);
        ref_pulses(N_EDGES - 1);
        check("R9 count cleared", fsm_hold, 1'b0);
        ref_pulses(1);
        check("R9 hold after five", fsm_hold, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule